// File: doc/BRIEF.md
# Parallel Triangle Code Generator

This block drives an 8-bit parallel digital-to-analogue converter with a triangle wave. A packed control word gives a step size and a half-cycle step count. When the generator is launched the code starts from zero. On each step tick it climbs by the step size for the programmed number of steps, then descends by the same step size for the same number of steps. The pattern repeats until reset. The peak of the wave is the step size times the half-cycle count, so amplitude is set mainly through the step size.

A control word is taken when the start strobe is high. The first legal word after reset launches the generator at once. A legal word that arrives while the wave is running is held back and applied when the current cycle has returned to zero, so the output never jumps. A word whose peak would not fit in 8 bits, or whose half-cycle count is zero, is refused and the error flag is raised. The configuration already in use, or already waiting, stays as it was. The word also carries a lane index. The block only passes this index on, for the converter-side logic to use.

Top module: `tri_wave_gen`

## Requirements
- R1: After reset, `dac_code` is 0, `cycle_done` is 0, `cfg_err` is 0 and `active_lane` is 0. Step ticks have no effect until a legal control word has been started.
- R2: A legal start while idle applies the word at once and holds `dac_code` at 0. The first rise happens on the next step tick.
- R3: The control word fields are: lane index in bits 7:0, step size in bits 15:8, half-cycle count P in bits 23:16. One cycle is P ticks that each add the step size, then P ticks that each subtract it, ending at 0.
- R4: `dac_code` changes only on a clock where `step_tick` is high, apart from the zeroing on launch.
- R5: `cycle_done` is high for exactly one clock, the clock in which `dac_code` has just returned to 0 at the end of a cycle.
- R6: A start with step size × P ≥ 256 or with P = 0 is refused. `cfg_err` is set and the active and pending configurations are unchanged. The next legal start clears `cfg_err`.
- R7: A legal start while running takes effect only at the end of the current cycle. The remaining steps of that cycle use the old step size and count.
- R8: `active_lane` shows the lane index of the configuration in use. It changes only on launch or at a cycle end.
- R9: Step size × P = 255 is legal and reaches a peak of 255. Step size 2 with P = 127 gives 254 ticks per cycle and a peak of 254.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Strobe: offer `cfg_word` |
| cfg_word | input | 24 | Packed lane / step / half-count word |
| step_tick | input | 1 | Advance the wave by one step |
| dac_code | output | 8 | Parallel code to the converter |
| cycle_done | output | 1 | One-clock pulse at each return to 0 |
| cfg_err | output | 1 | Last offered word was refused |
| active_lane | output | 8 | Lane index of the configuration in use |

## Verification
The bound checker checks the following on every clock: the code holds steady without a tick, the code is zero whenever the cycle-done pulse is high, that pulse never lasts two clocks, a refused word raises the error flag and leaves the lane unchanged, and the lane moves only on launch or at a cycle end. The exact shape of the wave cannot be shown by these per-clock properties. Only the bench scenarios can show it: the step-by-step ramp values, the 254 and 255 peaks, and the deferral of a new word across the rest of a running cycle. Those scenarios compare every tick against a model kept in the bench.

// File: rtl/tri_wave_pkg.sv
// Shared widths and types for the triangle generator.
// Assumes an 8-bit converter code and 8-bit control fields.
package tri_wave_pkg;
    localparam int unsigned FIELD_W = 8;
    localparam int unsigned WORD_W  = 3 * FIELD_W;

    // Control word layout: lane [7:0], step [15:8], half count [23:16]
    typedef struct packed {
        logic [FIELD_W-1:0] half_cnt;
        logic [FIELD_W-1:0] step;
        logic [FIELD_W-1:0] lane;
    } tri_cfg_t;

    typedef enum logic {
        DIR_RISE = 1'b0,
        DIR_FALL = 1'b1
    } tri_dir_e;
endpackage

// File: rtl/tri_cfg_ctrl.sv
// Control word intake: validates offered words, launches the generator,
// and holds a pending word until the running cycle wraps.
// Assumes start and wrap are single-clock qualified signals.
module tri_cfg_ctrl
    import tri_wave_pkg::*;
#(
    parameter int unsigned CODE_W = FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              wrap,
    output tri_cfg_t          act_cfg,
    output logic              running,
    output logic              launch,
    output logic              cfg_ok,
    output logic              cfg_err
);
    localparam int unsigned PROD_W = 2 * FIELD_W;
    localparam logic [PROD_W-1:0] CODE_SPAN = PROD_W'(1) << CODE_W;

    tri_cfg_t            offered;
    tri_cfg_t            pend_cfg;
    logic                pend_v;
    logic [PROD_W-1:0]   peak;

    // Unpack the offered word and compute its peak
    always_comb begin
        offered = tri_cfg_t'(cfg_word);
        peak    = PROD_W'(offered.step) * PROD_W'(offered.half_cnt);
        cfg_ok  = (offered.half_cnt != '0) && (peak < CODE_SPAN);
        launch  = start && cfg_ok && !running;
    end

    // Accept, refuse, defer and apply configurations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg  <= '0;
            pend_cfg <= '0;
            pend_v   <= 1'b0;
            running  <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            if (start) begin
                cfg_err <= !cfg_ok;
            end
            if (launch) begin
                act_cfg <= offered;
                running <= 1'b1;
            end else if (wrap && start && cfg_ok) begin
                act_cfg <= offered;
                pend_v  <= 1'b0;
            end else if (wrap && pend_v) begin
                act_cfg <= pend_cfg;
                pend_v  <= 1'b0;
            end else if (start && cfg_ok && running) begin
                pend_cfg <= offered;
                pend_v   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tri_step_seq.sv
// Step sequencer: counts steps within each half cycle and tracks direction.
// Assumes half_cnt is non-zero while running (guaranteed by intake).
module tri_step_seq
    import tri_wave_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               running,
    input  logic               launch,
    input  logic               step_tick,
    input  logic [FIELD_W-1:0] half_cnt,
    output logic               step_up,
    output logic               step_dn,
    output logic               wrap
);
    logic [FIELD_W-1:0] cnt;
    tri_dir_e           dir;
    logic               advance;
    logic               last;

    // Decode this clock's step action
    always_comb begin
        advance = running && step_tick && !launch;
        last    = (cnt == half_cnt - FIELD_W'(1));
        step_up = advance && (dir == DIR_RISE);
        step_dn = advance && (dir == DIR_FALL);
        wrap    = step_dn && last;
    end

    // Advance the step counter and flip direction at half-cycle ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dir <= DIR_RISE;
        end else if (launch) begin
            cnt <= '0;
            dir <= DIR_RISE;
        end else if (advance) begin
            if (last) begin
                cnt <= '0;
                dir <= (dir == DIR_RISE) ? DIR_FALL : DIR_RISE;
            end else begin
                cnt <= cnt + FIELD_W'(1);
            end
        end
    end
endmodule

// File: rtl/tri_code_acc.sv
// Code accumulator: adds or subtracts the step size and flags cycle ends.
// Assumes the intake never admits a peak beyond the code range.
module tri_code_acc
    import tri_wave_pkg::*;
#(
    parameter int unsigned CODE_W = FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               step_up,
    input  logic               step_dn,
    input  logic               wrap,
    input  logic [FIELD_W-1:0] step,
    output logic [CODE_W-1:0]  code,
    output logic               done
);
    // Update the output code on launch or on a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (launch) begin
            code <= '0;
        end else if (step_up) begin
            code <= code + CODE_W'(step);
        end else if (step_dn) begin
            code <= code - CODE_W'(step);
        end
    end

    // Register the one-clock cycle-end pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else begin
            done <= wrap;
        end
    end
endmodule

// File: rtl/tri_wave_gen.sv
// Top of the parallel triangle generator: intake, sequencer, accumulator.
// Assumes step_tick is synchronous to clk; converter timing is external.
module tri_wave_gen
    import tri_wave_pkg::*;
#(
    parameter int unsigned CODE_W = FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              step_tick,
    output logic [CODE_W-1:0] dac_code,
    output logic              cycle_done,
    output logic              cfg_err,
    output logic [FIELD_W-1:0] active_lane
);
    tri_cfg_t act_cfg;
    logic     running;
    logic     launch;
    logic     cfg_ok;
    logic     step_up;
    logic     step_dn;
    logic     wrap;

    tri_cfg_ctrl #(.CODE_W(CODE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_word (cfg_word),
        .wrap     (wrap),
        .act_cfg  (act_cfg),
        .running  (running),
        .launch   (launch),
        .cfg_ok   (cfg_ok),
        .cfg_err  (cfg_err)
    );

    tri_step_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .running   (running),
        .launch    (launch),
        .step_tick (step_tick),
        .half_cnt  (act_cfg.half_cnt),
        .step_up   (step_up),
        .step_dn   (step_dn),
        .wrap      (wrap)
    );

    tri_code_acc #(.CODE_W(CODE_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .step_up (step_up),
        .step_dn (step_dn),
        .wrap    (wrap),
        .step    (act_cfg.step),
        .code    (dac_code),
        .done    (cycle_done)
    );

    // Expose the lane index of the configuration in use
    always_comb active_lane = act_cfg.lane;
endmodule

// File: rtl/tri_wave_chk.sv
// Protocol checker for tri_wave_gen, attached by bind.
module tri_wave_chk
    import tri_wave_pkg::*;
#(
    parameter int unsigned CODE_W = FIELD_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               step_tick,
    input logic [CODE_W-1:0]  dac_code,
    input logic               cycle_done,
    input logic               cfg_err,
    input logic [FIELD_W-1:0] active_lane,
    input logic               cfg_ok,
    input logic               launch
);
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_tick && !start) |=> $stable(dac_code));

    // R5
    done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (dac_code == '0));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);

    // R6
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cfg_ok) |=> (cfg_err && $stable(active_lane)));

    // R8
    lane_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_lane) |-> (cycle_done || $past(launch)));
endmodule

bind tri_wave_gen tri_wave_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .step_tick   (step_tick),
    .dac_code    (dac_code),
    .cycle_done  (cycle_done),
    .cfg_err     (cfg_err),
    .active_lane (active_lane),
    .cfg_ok      (cfg_ok),
    .launch      (launch)
);

// File: tb/tri_wave_gen_tb.sv
module tri_wave_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] cfg_word = '0;
    logic        step_tick = 1'b0;
    logic [7:0]  dac_code;
    logic        cycle_done;
    logic        cfg_err;
    logic [7:0]  active_lane;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench model of the wave
    bit m_run = 0, p_v = 0, m_err = 0, m_done = 0;
    int m_inc = 0, m_per = 0, m_lane = 0, m_idx = 0, m_code = 0;
    int p_inc = 0, p_per = 0, p_lane = 0;

    always #10 clk = ~clk;   // 50 MHz

    tri_wave_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word),
        .step_tick(step_tick), .dac_code(dac_code), .cycle_done(cycle_done),
        .cfg_err(cfg_err), .active_lane(active_lane)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(dac_code, m_code, {tag, " code"});
        chk(cycle_done, m_done, {tag, " cycle_done"});
        chk(cfg_err, m_err, {tag, " cfg_err"});
        chk(active_lane, m_lane, {tag, " lane"});
    endtask

    task automatic do_start(input int inc, input int per, input int lane, input string tag);
        @(negedge clk);
        cfg_word = {8'(per), 8'(inc), 8'(lane)};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_done = 0;
        if (per == 0 || inc * per >= 256) begin
            m_err = 1;
        end else begin
            m_err = 0;
            if (!m_run) begin
                m_run = 1; m_inc = inc; m_per = per; m_lane = lane;
                m_idx = 0; m_code = 0;
            end else begin
                p_v = 1; p_inc = inc; p_per = per; p_lane = lane;
            end
        end
        chk_all(tag);
    endtask

    task automatic do_tick(input string tag);
        @(negedge clk);
        step_tick = 1'b1;
        @(negedge clk);
        step_tick = 1'b0;
        m_done = 0;
        if (m_run) begin
            if (m_idx < m_per) m_code += m_inc; else m_code -= m_inc;
            m_idx++;
            if (m_idx == 2 * m_per) begin
                m_idx = 0; m_done = 1;
                if (p_v) begin
                    m_inc = p_inc; m_per = p_per; m_lane = p_lane; p_v = 0;
                end
            end
        end
        chk_all(tag);
    endtask

    task automatic run_to_end(input string tag);
        do_tick(tag);
        while (!m_done) do_tick(tag);
    endtask

    // R1: reset state and ticks ignored while idle
    task automatic t_reset();
        chk_all("R1 reset");
        for (int i = 0; i < 3; i++) do_tick("R1 idle tick");
    endtask

    // R2 R3 R5 R9: reference 2 x 127 cycle
    task automatic t_ref_cycle();
        do_start(2, 127, 5, "R2 launch");
        for (int i = 0; i < 127; i++) do_tick("R3 rise");
        chk(dac_code, 254, "R9 peak 254");
        for (int i = 0; i < 127; i++) do_tick("R3 fall");
        chk(cycle_done, 1, "R5 done at end");
        @(negedge clk);
        m_done = 0;
        chk(cycle_done, 0, "R5 done one clock");
        chk(dac_code, 0, "R3 back to zero");
    endtask

    // R4: code holds without ticks
    task automatic t_hold();
        for (int i = 0; i < 10; i++) do_tick("R4 pre");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(dac_code, m_code, "R4 hold");
        end
    endtask

    // R6 R7 R8: refused words, then a deferred legal word
    task automatic t_reject_defer();
        do_start(16, 16, 9, "R6 reject 256");
        do_start(4, 0, 9, "R6 reject zero count");
        for (int i = 0; i < 3; i++) do_tick("R6 old shape kept");
        do_start(1, 1, 7, "R6 err cleared");
        do_tick("R7 old step still used");
        chk(active_lane, 5, "R8 lane before wrap");
        run_to_end("R7 finish old cycle");
        chk(active_lane, 7, "R8 lane after wrap");
        do_tick("R7 new rise");
        chk(dac_code, 1, "R7 new step size");
        do_tick("R7 new fall");
        chk(cycle_done, 1, "R5 short cycle done");
    endtask

    // R9: boundary product 255 legal, peak 255
    task automatic t_boundary();
        do_start(15, 17, 3, "R9 defer 255");
        do_tick("R9 finish 1x1 rise");
        do_tick("R9 finish 1x1 fall");
        chk(active_lane, 3, "R8 lane 3");
        for (int i = 0; i < 17; i++) do_tick("R9 rise");
        chk(dac_code, 255, "R9 peak 255");
        run_to_end("R9 fall");
        chk(dac_code, 0, "R9 end zero");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ref_cycle();
        t_hold();
        run_to_end("R3 drain");
        t_reject_defer();
        t_boundary();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule